// File: doc/BRIEF.md
# Cascaded Serial Switch-Chain Loader

This block sits on the host side of a daisy chain of identical serial switch-control devices. Each device holds a 16-bit shift stage, and every device feeds the next one. When the host raises a one-cycle start request, the loader takes a parallel pattern that holds one bit for every switch in the chain. It shifts the pattern out on a serial data line and a divided shift clock, and it pulses an active-low latch enable so that every device updates its switches in the same instant. A separate one-cycle clear request makes the loader issue a timed clear pulse, which turns off every switch in the chain.

All timing is counted in cycles of the system clock. `HALF_CYC` sets each phase of the shift clock. `GAP_CYC` sets the idle time between the last falling shift edge and the latch pulse. `LE_CYC` and `CLR_CYC` set the pulse widths. With the default values and a 50 MHz system clock, the shift clock runs at 6.25 MHz. The latch enable stays high for 2 cycles after the last falling shift edge, and both pulses last 60 ns. These values meet the device limits at a 3 V logic supply.

Pattern bit `d*16+k` controls channel `k` of device `d`. Device 0 is the device wired directly to the loader.

Top module: `chain_loader`

## Requirements
- R1: After reset, `busy`, `shiftClk` and `clearOut` are 0, `latchN` is 1, and `serData` is 0.
- R2: An accepted start or clear request makes `busy` read 1 from the next cycle on. `busy` returns to 0 in the same cycle that `latchN` (or `clearOut`) ends its pulse.
- R3: Each update gives exactly `NUM_DEV*16` rising edges of `shiftClk`. The bits are sent starting at the highest pattern bit, that is the farthest device and its channel 15, and ending at bit 0. As a result, after the latch pulse, device `d` channel `k` holds pattern bit `d*16+k`.
- R4: Each high phase and each low phase of `shiftClk` lasts `HALF_CYC` cycles. `serData` changes only in the cycle in which `shiftClk` falls, or when the pattern is loaded, and it stays stable while `shiftClk` is high.
- R5: `latchN` is 1 at every rising edge of `shiftClk`. `latchN` falls `HALF_CYC+GAP_CYC` cycles after the last rising edge.
- R6: `latchN` goes low once per update, for exactly `LE_CYC` cycles.
- R7: A clear request raises `clearOut` (active high) for exactly `CLR_CYC` cycles. No shift clock runs during the clear. Afterwards every switch reads off (0) until the next update.
- R8: A start request or a clear request that arrives while `busy` is 1 is ignored. The update in progress completes with its original pattern.
- R9: If a start request and a clear request arrive in the same idle cycle, the clear is performed and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | One-cycle request to load `pattern` |
| pattern | input | NUM_DEV*16 | Switch pattern, sampled when a start request is accepted |
| clearReq | input | 1 | One-cycle request for a clear pulse |
| busy | output | 1 | An update or clear pulse is in progress |
| serData | output | 1 | Serial data to the first device |
| shiftClk | output | 1 | Shift clock; the devices sample on its rising edge |
| latchN | output | 1 | Latch enable, active low |
| clearOut | output | 1 | Clear pulse to all devices, active high |

## Verification
Suppose the bit counter or the shift register inside the loader goes wrong. Every device in the chain then ends up holding a shifted or wrong pattern, and the bench's chain model shows the wrong switch states as soon as the latch pulse ends. The wrong rise count is already visible at the moment `latchN` falls.

A wrong phase or pulse timer shows within one pulse. It appears as a `shiftClk` phase, a latch width or a clear width that differs from its parameter, or as `serData` moving while the clock is high.

If the state machine fails to guard its idle state, the next request exposes it. A late request then restarts the shift, which adds rising edges, or raises `clearOut` in the middle of an update.

// File: rtl/chain_loader_pkg.sv
package chain_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_LATCH,
    ST_CLEAR
  } loadStateT;

  typedef struct packed {
    logic load;
    logic shift;
  } ldStrobeT;

endpackage

// File: rtl/chain_datapath.sv
module chain_datapath
  import chain_loader_pkg::*;
#(
  parameter int TOTAL_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ldStrobeT              strobe,
  input  logic [TOTAL_BITS-1:0] pattern,
  output logic                  serData
);

  logic [TOTAL_BITS-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobe.load) begin
      shReg <= pattern;
    end else if (strobe.shift) begin
      shReg <= {shReg[TOTAL_BITS-2:0], 1'b0};
    end
  end

  // MSB first: farthest device, channel 15, leaves first
  assign serData = shReg[TOTAL_BITS-1];

  // R3: load and shift are never requested in the same cycle
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.shift));

endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_loader_pkg::*;
#(
  parameter int TOTAL_BITS = 32,
  parameter int HALF_CYC   = 4,
  parameter int GAP_CYC    = 2,
  parameter int LE_CYC     = 3,
  parameter int CLR_CYC    = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     clearReq,
  output ldStrobeT strobe,
  output logic     busy,
  output logic     shiftClk,
  output logic     latchN,
  output logic     clearOut
);

  localparam int MAX_AB = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
  localparam int MAX_CD = (LE_CYC > CLR_CYC) ? LE_CYC : CLR_CYC;
  localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W  = $clog2(MAX_T + 1);
  localparam int BIT_W  = $clog2(TOTAL_BITS + 1);

  loadStateT        state, nextState;
  logic [TMR_W-1:0] timer, nextTimer;
  logic [BIT_W-1:0] bitCnt, nextBit;

  always_comb begin
    nextState = state;
    nextTimer = timer;
    nextBit   = bitCnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (clearReq) begin
          nextState = ST_CLEAR;
          nextTimer = TMR_W'(CLR_CYC - 1);
        end else if (startReq) begin
          nextState   = ST_LOW;
          nextTimer   = TMR_W'(HALF_CYC - 1);
          nextBit     = '0;
          strobe.load = 1'b1;
        end
      end
      ST_LOW: begin
        if (timer == '0) begin
          nextState = ST_HIGH;
          nextTimer = TMR_W'(HALF_CYC - 1);
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      ST_HIGH: begin
        if (timer == '0) begin
          strobe.shift = 1'b1;
          if (bitCnt == BIT_W'(TOTAL_BITS - 1)) begin
            nextState = ST_GAP;
            nextTimer = TMR_W'(GAP_CYC - 1);
          end else begin
            nextState = ST_LOW;
            nextTimer = TMR_W'(HALF_CYC - 1);
            nextBit   = bitCnt + 1'b1;
          end
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      ST_GAP: begin
        if (timer == '0) begin
          nextState = ST_LATCH;
          nextTimer = TMR_W'(LE_CYC - 1);
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      ST_LATCH, ST_CLEAR: begin
        if (timer == '0) nextState = ST_IDLE;
        else             nextTimer = timer - 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      bitCnt   <= '0;
      busy     <= 1'b0;
      shiftClk <= 1'b0;
      latchN   <= 1'b1;
      clearOut <= 1'b0;
    end else begin
      state    <= nextState;
      timer    <= nextTimer;
      bitCnt   <= nextBit;
      busy     <= (nextState != ST_IDLE);
      shiftClk <= (nextState == ST_HIGH);
      latchN   <= (nextState != ST_LATCH);
      clearOut <= (nextState == ST_CLEAR);
    end
  end

  // checker counters for pulse widths and edge counts
  logic [TMR_W:0]   leRun, clrRun;
  logic [BIT_W-1:0] riseSeen;
  logic             clkDly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leRun    <= '0;
      clrRun   <= '0;
      riseSeen <= '0;
      clkDly   <= 1'b0;
    end else begin
      clkDly <= shiftClk;
      leRun  <= latchN   ? '0 : leRun + 1'b1;
      clrRun <= clearOut ? clrRun + 1'b1 : '0;
      if (latchN && !clkDly && shiftClk) riseSeen <= riseSeen + 1'b1;
      else if (!latchN)                  riseSeen <= '0;
    end
  end

  assert_le_high_when_clocking_R5: assert property (@(posedge clk) disable iff (!rstN)
    shiftClk |-> latchN);

  assert_le_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchN) |-> (leRun == (TMR_W+1)'(LE_CYC)));

  assert_clr_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clearOut) |-> (clrRun == (TMR_W+1)'(CLR_CYC)));

  assert_clr_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    clearOut |-> (latchN && !shiftClk));

  assert_rise_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(latchN) |-> (riseSeen == BIT_W'(TOTAL_BITS)));

  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |-> !strobe.load);

  assert_busy_ends_with_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (latchN && !clearOut && ($past(!latchN) || $past(clearOut))));

endmodule

// File: rtl/chain_loader.sv
module chain_loader
  import chain_loader_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int WORD_W   = 16,
  parameter int HALF_CYC = 4,
  parameter int GAP_CYC  = 2,
  parameter int LE_CYC   = 3,
  parameter int CLR_CYC  = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startReq,
  input  logic [NUM_DEV*WORD_W-1:0] pattern,
  input  logic                      clearReq,
  output logic                      busy,
  output logic                      serData,
  output logic                      shiftClk,
  output logic                      latchN,
  output logic                      clearOut
);

  localparam int TOTAL_BITS = NUM_DEV * WORD_W;

  ldStrobeT strobe;

  chain_ctrl #(
    .TOTAL_BITS(TOTAL_BITS), .HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC),
    .LE_CYC(LE_CYC), .CLR_CYC(CLR_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .clearReq(clearReq),
    .strobe(strobe), .busy(busy), .shiftClk(shiftClk), .latchN(latchN),
    .clearOut(clearOut)
  );

  chain_datapath #(.TOTAL_BITS(TOTAL_BITS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pattern(pattern), .serData(serData)
  );

  // R4: data from the datapath holds while the control drives the clock high
  assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk && $past(shiftClk)) |-> $stable(serData));

endmodule

// File: tb/sim_chain_loader.sv
module sim_chain_loader;

  localparam int NUM_DEV  = 2;
  localparam int WORD_W   = 16;
  localparam int TOTAL    = NUM_DEV * WORD_W;
  localparam int HALF_CYC = 4;
  localparam int GAP_CYC  = 2;
  localparam int LE_CYC   = 3;
  localparam int CLR_CYC  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic clearReq = 1'b0;
  logic [TOTAL-1:0] pattern = '0;
  logic busy, serData, shiftClk, latchN, clearOut;

  always #10 clk = ~clk;

  chain_loader #(
    .NUM_DEV(NUM_DEV), .WORD_W(WORD_W), .HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC),
    .LE_CYC(LE_CYC), .CLR_CYC(CLR_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pattern(pattern),
    .clearReq(clearReq), .busy(busy), .serData(serData), .shiftClk(shiftClk),
    .latchN(latchN), .clearOut(clearOut)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural chain: bit d*16+k is channel k of device d
  logic [TOTAL-1:0] chainSr = '0;
  logic [TOTAL-1:0] switches = '0;
  always @(posedge shiftClk) chainSr <= {chainSr[TOTAL-2:0], serData};
  always @(negedge clk) begin
    if (clearOut)     switches <= '0;
    else if (!latchN) switches <= chainSr;
  end

  // port timing monitor, sampled mid-cycle
  logic prevClk = 0, prevLe = 1, prevClr = 0, prevData = 0;
  int riseCnt = 0, highRun = 0, leRun = 0, clrRun = 0, sinceRise = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (shiftClk && !prevClk) begin
        sinceRise = 0;
        riseCnt++;
        check(latchN == 1'b1, "R5 latch high at rise", latchN, 1);
      end else begin
        sinceRise++;
      end
      if (shiftClk && prevClk)
        check(serData == prevData, "R4 data stable while clock high", serData, prevData);
      if (shiftClk) highRun++;
      if (prevClk && !shiftClk) begin
        check(highRun == HALF_CYC, "R4 high phase width", highRun, HALF_CYC);
        highRun = 0;
      end
      if (prevLe && !latchN) begin
        check(riseCnt == TOTAL, "R3 rising edges per update", riseCnt, TOTAL);
        check(sinceRise == HALF_CYC + GAP_CYC, "R5 last rise to latch", sinceRise, HALF_CYC + GAP_CYC);
      end
      if (!latchN) leRun++;
      if (!prevLe && latchN) begin
        check(leRun == LE_CYC, "R6 latch pulse width", leRun, LE_CYC);
        leRun = 0;
        riseCnt = 0;
      end
      if (clearOut) clrRun++;
      if (prevClr && !clearOut) begin
        check(clrRun == CLR_CYC, "R7 clear pulse width", clrRun, CLR_CYC);
        check(riseCnt == 0, "R7 no shift clock during clear", riseCnt, 0);
        clrRun = 0;
      end
    end
    prevClk = shiftClk;
    prevLe = latchN;
    prevClr = clearOut;
    prevData = serData;
  end

  task automatic waitIdle(input string req);
    bit lastLow = 0;
    int n = 0;
    while (busy && n < 2000) begin
      lastLow = !latchN || clearOut;
      @(negedge clk);
      n++;
    end
    check(!busy && lastLow, req, busy, 0);
  endtask

  task automatic doLoad(input logic [TOTAL-1:0] pat);
    @(negedge clk);
    pattern = pat;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    waitIdle("R2 busy ends with latch pulse");
  endtask

  task automatic doClear();
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    check(busy && clearOut, "R7 clear started", {busy, clearOut}, 2'b11);
    waitIdle("R2 busy ends with clear pulse");
  endtask

  // {isClear, pattern, expected switches}
  localparam logic [2*TOTAL:0] VECS [0:6] = '{
    {1'b0, 32'hA5C3_0F81, 32'hA5C3_0F81},
    {1'b0, 32'h8000_0000, 32'h8000_0000},
    {1'b0, 32'h0000_0001, 32'h0000_0001},
    {1'b0, 32'h0001_8000, 32'h0001_8000},
    {1'b1, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 32'h1234_FEDC, 32'h1234_FEDC}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy, shiftClk, clearOut, latchN, serData} == 5'b00010, "R1 reset outputs",
          {busy, shiftClk, clearOut, latchN, serData}, 5'b00010);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(latchN && !busy, "R1 idle after reset", {latchN, busy}, 2'b10);

    for (int i = 0; i < 7; i++) begin
      if (VECS[i][2*TOTAL]) doClear();
      else doLoad(VECS[i][2*TOTAL-1:TOTAL]);
      repeat (2) @(negedge clk);
      check(switches == VECS[i][TOTAL-1:0], VECS[i][2*TOTAL] ? "R7 switches off" : "R3 chain contents",
            switches, VECS[i][TOTAL-1:0]);
    end

    // R8: requests during an update are ignored
    @(negedge clk);
    pattern = 32'h0F0F_3C3C;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (10) @(negedge clk);
    pattern = 32'hDEAD_BEEF;
    startReq = 1'b1;
    clearReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    clearReq = 1'b0;
    @(negedge clk);
    check(clearOut == 1'b0, "R8 clear ignored while busy", clearOut, 0);
    waitIdle("R8 update completes");
    repeat (2) @(negedge clk);
    check(switches == 32'h0F0F_3C3C, "R8 original pattern kept", switches, 32'h0F0F_3C3C);

    // R9: clear wins over a simultaneous start
    @(negedge clk);
    pattern = 32'h5555_AAAA;
    startReq = 1'b1;
    clearReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    clearReq = 1'b0;
    check(clearOut && !shiftClk, "R9 clear has priority", {clearOut, shiftClk}, 2'b10);
    waitIdle("R9 clear ends");
    repeat (HALF_CYC + 4) @(negedge clk);
    check(switches == '0 && !shiftClk, "R9 start dropped", switches, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule